// File: doc/BRIEF.md
# Character display RAM access unit

This block carries out the instructions that touch the memories of a character display controller. It sits behind a parallel host bus made of a register select, a read/write line, an enable strobe and an 8-bit data bus. It holds the display-data RAM (128 bytes) and the character-generator RAM (64 five-bit glyph rows). One 7-bit address counter serves both arrays. Whichever set-address instruction the host issued last decides which array later data writes and data reads use.

The host strobes are synchronized into the core clock. Each instruction takes effect on the detected falling edge of the enable. Reads are prefetched: a data register holds the byte that the next data read returns. Only the two set-address instructions and the data read itself refill that register. After every write-type instruction a busy flag is raised for a fixed number of core cycles. Any instruction whose strobe completes during that time is dropped. The entry-mode direction arrives on a dedicated input and chooses whether the counter steps up or down.

Top module: `cdisp_ram_access`

## Requirements
- R1: After reset the address counter is 0, busy_o is 0, the data register is 0, the display-data RAM is selected, and db_o is 0 while en_i is low.
- R2: An instruction with rs_i=0, rw_i=0 and db_i[7:6]=01 selects the character-generator RAM and loads counter bits 5..0 from db_i[5:0]. Counter bit 6 keeps its previous value.
- R3: An instruction with rs_i=0, rw_i=0 and db_i[7]=1 selects the display-data RAM and loads all 7 counter bits from db_i[6:0].
- R4: A data write (rs_i=1, rw_i=0) stores db_i at the counter address of the selected RAM. In the character-generator RAM the entry is indexed by counter bits 5..0 and holds only db_i[4:0]. Reading that entry back returns bits 7..5 as 0.
- R5: After a data write the counter steps by +1 when dir_up_i=1 and by -1 when dir_up_i=0, wrapping modulo 128.
- R6: A data read (rs_i=1, rw_i=1) drives the data register onto db_o while en_i is high. After the enable falls, the counter steps in the entry direction and the data register is refilled from the selected RAM at the new counter value.
- R7: Each set-address instruction refills the data register from the newly addressed location of the newly selected RAM.
- R8: A data write leaves the data register unchanged. An instruction with rs_i=0, rw_i=0 and db_i[7:6]=00 changes neither the counter nor the data register.
- R9: A status read (rs_i=0, rw_i=1) drives {busy flag, counter} onto db_o while en_i is high, with the busy flag on bit 7 and the counter on bits 6..0.
- R10: busy_o is high for exactly BUSY_CYC core cycles after each executed set-address or data-write instruction.
- R11: An instruction whose enable falls while busy_o is high is not executed.
- R12: Instructions act only after the enable falls. db_o is 0 whenever en_i or rw_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| en_i | input | 1 | Host enable strobe, acts on its falling edge |
| dir_up_i | input | 1 | Entry direction: 1 increment, 0 decrement |
| db_i | input | 8 | Host write data |
| db_o | output | 8 | Host read data, valid while en_i is high |
| busy_o | output | 1 | Internal operation in progress |

## Verification
The bench writes every display-data address in both entry directions. It reads everything back through the prefetch register, so a design that returned the byte at the old address, or skipped the refill after reading, would be off by one location throughout. It fills the whole character-generator RAM and lets the counter carry into bit 6. The following set-address must keep that bit, and a design that cleared it would show a different counter value on the status read. The bench also checks that the prefetch byte survives a data write, that reads from the glyph array mask the upper data bits, that the counter wraps at both ends, that a strobe landing inside the busy window is dropped, and that the busy flag lasts exactly BUSY_CYC cycles.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_CG,
    OP_SET_DD,
    OP_WRITE,
    OP_READ
  } op_e;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] bus_i,
  output logic         fall_o,
  output logic [W-1:0] bus_o
);
  logic [STAGES:0] en_q;
  logic [W-1:0]    bus_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      bus_q[0] <= '0;
    end else begin
      en_q     <= {en_q[STAGES-1:0], en_i};
      bus_q[0] <= bus_i;
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bus_q[k] <= '0;
      else         bus_q[k] <= bus_q[k-1];
    end
  end

  assign fall_o = en_q[STAGES] & ~en_q[STAGES-1];
  assign bus_o  = bus_q[STAGES-1];
endmodule

// File: rtl/cdr_decode.sv
module cdr_decode #(
  parameter int DW = 8
) (
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic [DW-1:0] db_i,
  output cdr_pkg::op_e  op_o
);
  import cdr_pkg::*;
  always_comb begin
    unique case ({rs_i, rw_i})
      2'b00:   op_o = db_i[DW-1] ? OP_SET_DD : (db_i[DW-2] ? OP_SET_CG : OP_NONE);
      2'b10:   op_o = OP_WRITE;
      2'b11:   op_o = OP_READ;
      default: op_o = OP_NONE; // status read has no internal action
    endcase
  end
endmodule

// File: rtl/cdr_busy.sv
module cdr_busy #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cdisp_ram_access.sv
module cdisp_ram_access #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int CG_AW       = 6,
  parameter int CG_DW       = 5,
  parameter int BUSY_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic          en_i,
  input  logic          dir_up_i,
  input  logic [DW-1:0] db_i,
  output logic [DW-1:0] db_o,
  output logic          busy_o
);
  import cdr_pkg::*;
  localparam int DD_DEPTH = 1 << AW;
  localparam int CG_DEPTH = 1 << CG_AW;
  localparam int BW       = DW + 2;

  logic          fall;
  logic [BW-1:0] bus_s;
  logic          rs_s, rw_s;
  logic [DW-1:0] db_s;
  op_e           op;
  logic          exec;

  cdr_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .en_i,
    .bus_i ({rs_i, rw_i, db_i}),
    .fall_o(fall),
    .bus_o (bus_s)
  );
  assign {rs_s, rw_s, db_s} = bus_s;

  cdr_decode #(.DW(DW)) u_dec (.rs_i(rs_s), .rw_i(rw_s), .db_i(db_s), .op_o(op));

  assign exec = fall & ~busy_o;

  logic [AW-1:0] ac_q, ac_new, ac_step;
  logic [DW-1:0] dr_q, rd_data;
  logic          sel_cg_q, sel_new;

  logic [DW-1:0]    dd_mem [DD_DEPTH];
  logic [CG_DW-1:0] cg_mem [CG_DEPTH];

  assign ac_step = dir_up_i ? ac_q + 1'b1 : ac_q - 1'b1;

  always_comb begin
    ac_new  = ac_q;
    sel_new = sel_cg_q;
    unique case (op)
      OP_SET_CG: begin
        ac_new  = {ac_q[AW-1:CG_AW], db_s[CG_AW-1:0]}; // top bit kept
        sel_new = 1'b1;
      end
      OP_SET_DD: begin
        ac_new  = db_s[AW-1:0];
        sel_new = 1'b0;
      end
      OP_WRITE, OP_READ: ac_new = ac_step;
      default: ;
    endcase
  end

  assign rd_data = sel_new ? {{(DW-CG_DW){1'b0}}, cg_mem[ac_new[CG_AW-1:0]]}
                           : dd_mem[ac_new];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q     <= '0;
      dr_q     <= '0;
      sel_cg_q <= 1'b0;
    end else if (exec) begin
      ac_q     <= ac_new;
      sel_cg_q <= sel_new;
      if (op inside {OP_SET_CG, OP_SET_DD, OP_READ}) dr_q <= rd_data;
    end
  end

  always_ff @(posedge clk_i) begin
    if (exec && op == OP_WRITE) begin
      if (sel_cg_q) cg_mem[ac_q[CG_AW-1:0]] <= db_s[CG_DW-1:0];
      else          dd_mem[ac_q]            <= db_s;
    end
  end

  cdr_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni,
    .start_i(exec && (op inside {OP_SET_CG, OP_SET_DD, OP_WRITE})),
    .busy_o
  );

  always_comb begin
    db_o = '0;
    if (en_i && rw_i) db_o = rs_i ? dr_q : DW'({busy_o, ac_q});
  end
endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fall_i,
  input logic          exec_i,
  input logic          busy_i,
  input cdr_pkg::op_e  op_i,
  input logic          dir_up_i,
  input logic [AW-1:0] ac_i,
  input logic [DW-1:0] dr_i
);
  import cdr_pkg::*;

  AST_AC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(ac_i)); // R12
  AST_AC_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_WRITE && dir_up_i |=> ac_i == AW'($past(ac_i) + 1'b1)); // R5
  AST_AC_STEP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_WRITE && !dir_up_i |=> ac_i == AW'($past(ac_i) - 1'b1)); // R5
  AST_CG_TOP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_SET_CG |=> ac_i[AW-1] == $past(ac_i[AW-1])); // R2
  AST_DR_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_WRITE |=> $stable(dr_i)); // R8
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && busy_i |=> $stable(ac_i) && $stable(dr_i)); // R11
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i inside {OP_SET_CG, OP_SET_DD, OP_WRITE} |=> busy_i); // R10
endmodule

bind cdisp_ram_access cdr_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni,
  .fall_i  (fall),
  .exec_i  (exec),
  .busy_i  (busy_o),
  .op_i    (op),
  .dir_up_i,
  .ac_i    (ac_q),
  .dr_i    (dr_q)
);

// File: tb/sim_cdisp_ram_access.sv
module sim_cdisp_ram_access;
  localparam int BUSY = 12;
  localparam int GAP  = BUSY + 10;

  logic       clk = 0, rst_n = 0;
  logic       rs = 0, rw = 0, en = 0, dir_up = 1;
  logic [7:0] db = 0;
  logic [7:0] db_o;
  logic       busy;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cdisp_ram_access #(.BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rs_i(rs), .rw_i(rw), .en_i(en),
    .dir_up_i(dir_up), .db_i(db), .db_o(db_o), .busy_o(busy)
  );

  function automatic logic [7:0] dval(int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] cval(int i); return 8'((i * 7 + 224) & 255); endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic r, input logic [7:0] d);
    @(negedge clk); rs = r; rw = 0; db = d;
    @(negedge clk); en = 1;
    repeat (3) @(negedge clk);
    en = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic rd(input logic r, output logic [7:0] v);
    @(negedge clk); rs = r; rw = 1;
    @(negedge clk); en = 1;
    repeat (2) @(negedge clk);
    v = db_o;
    en = 0;
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    chk("R1 db idle", db_o, 8'h00);
    rd(0, v); chk("R1 counter", v, 8'h00);
    rd(1, v); chk("R1 data reg", v, 8'h00);

    // R12: write held with en high must not act early; output 0 with rw low
    @(negedge clk); rs = 1; rw = 0; db = 8'h3C;
    @(negedge clk); en = 1;
    repeat (6) @(negedge clk);
    chk("R12 no early busy", {7'b0, busy}, 8'h00);
    chk("R12 db with rw low", db_o, 8'h00);
    en = 0;
    repeat (GAP) @(negedge clk);

    // R3 R4 R5 R6 R7: fill display RAM upward, read back
    dir_up = 1;
    wr(0, 8'h80);
    for (int i = 0; i < 128; i++) wr(1, dval(i));
    rd(0, v); chk("R5 wrap up", v, 8'h00);
    wr(0, 8'h80);
    for (int i = 0; i < 128; i++) begin rd(1, v); chk("R6 dd read up", v, dval(i)); end

    // R5 R6 decrement with wrap
    dir_up = 0;
    wr(0, 8'hFF);
    rd(0, v); chk("R3 full load", v, 8'h7F);
    for (int i = 0; i < 128; i++) begin rd(1, v); chk("R6 dd read down", v, dval(127 - i)); end
    rd(0, v); chk("R5 wrap down", v, 8'h7F);
    wr(0, 8'h80);
    wr(1, 8'h5A);
    rd(0, v); chk("R5 write down wrap", v, 8'h7F);
    wr(0, 8'h80);
    rd(1, v); chk("R4 dd write", v, 8'h5A);
    wr(0, 8'h80); dir_up = 1; wr(1, dval(0));

    // R2 R4: glyph RAM fill, carry into bit 6
    wr(0, 8'h80);
    wr(0, 8'h40);
    rd(0, v); chk("R2 cg load", v, 8'h00);
    for (int i = 0; i < 64; i++) wr(1, cval(i));
    rd(0, v); chk("R5 carry bit6", v, 8'h40);
    wr(0, 8'h45);
    rd(0, v); chk("R2 bit6 kept", v, 8'h45);
    rd(1, v); chk("R7 cg prefetch", v, cval(5) & 8'h1F);
    dir_up = 0;
    wr(0, 8'h7F);
    rd(0, v); chk("R2 cg top", v, 8'h7F);
    for (int i = 0; i < 64; i++) begin rd(1, v); chk("R4 cg read masked", v, cval(63 - i) & 8'h1F); end

    // R8: write keeps data register; other codes do nothing
    dir_up = 1;
    wr(0, 8'h90);
    wr(1, 8'hAA);
    rd(1, v); chk("R8 dr after write", v, dval(16));
    rd(0, v); chk("R6 step after read", v, 8'h12);
    wr(0, 8'h01);
    rd(0, v); chk("R8 other code ac", v, 8'h12);
    rd(1, v); chk("R8 other code dr", v, dval(18));

    // R9 R10 R11: busy window
    wr(0, 8'hA0);
    @(negedge clk); rs = 1; rw = 0; db = 8'h77;
    @(negedge clk); en = 1;
    repeat (3) @(negedge clk);
    en = 0;
    hi = 0;
    while (!busy && hi < 20) begin @(negedge clk); hi++; end
    hi = 0;
    while (busy && hi < 100) begin @(negedge clk); hi++; end
    chk("R10 busy length", 8'(hi), 8'(BUSY));
    repeat (GAP) @(negedge clk);

    @(negedge clk); rs = 1; rw = 0; db = 8'h66;
    @(negedge clk); en = 1;
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk); rs = 0; rw = 0; db = 8'h83;
    @(negedge clk); en = 1;
    repeat (2) @(negedge clk);
    en = 0;
    repeat (2) @(negedge clk);
    rs = 0; rw = 1; en = 1;
    @(negedge clk);
    chk("R9 busy bit", db_o & 8'h80, 8'h80);
    chk("R9 counter bits", db_o & 8'h7F, 8'h22);
    en = 0;
    repeat (GAP) @(negedge clk);
    rd(0, v); chk("R11 dropped instr", v, 8'h22);
    wr(0, 8'hA0);
    rd(1, v); chk("R4 write before drop", v, 8'h77);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule